// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a bus master that fetches one 16-bit word from a three-wire serial EEPROM of the select / clock / data-in / data-out kind. A one-cycle start request captures a word address, a choice between a 6-bit and an 8-bit address field, and a phase length. The block then frames the transfer with chip select, clocks out a read command, clocks in sixteen data bits, and presents the word alongside a one-cycle done pulse before it drops chip select.

The command is built as the address with the read opcode (binary 110) placed directly above it. Two zero bits lead, so the command is five bits longer than the address field. Every level the block drives on the serial wires is held for one phase. The phase length is a programmable number of system clocks, and a value of zero is treated as one. A start request that arrives while a read is under way has no effect. The block keeps no request queue.

Top module: `mw_eeprom_reader`

## Requirements
- R1: While rst_n is low at a clock edge, and after that edge, cs_o, sk_o, di_o and done_o are 0 and word_o is 0.
- R2: The command is shifted out MSB first on di_o: two 0 bits, then 1, 1, 0, then the address. With wide_i=1 the address is addr_i[7:0] (13 bits in all). With wide_i=0 it is addr_i[5:0] (11 bits in all), and addr_i[7:6] have no effect.
- R3: di_o changes only while sk_o is low. It is held constant for as long as sk_o is high.
- R4: After the command, sk_o pulses exactly 16 more times with di_o at 0. The bit present on do_i at the end of each high phase is captured, and the first capture becomes word_o[15].
- R5: Every phase lasts L = max(half_div_i, 1) system clocks, with half_div_i taken at the start request. The sequence is 1 select phase, 2 phases per command bit, 1 gap phase and 32 data phases. done_o therefore rises (2N+34)*L clocks after the edge that accepted start_i, where N is the command length.
- R6: cs_o stays low for the first phase after start. It is high whenever sk_o is high, and it is low again in the cycle after done_o.
- R7: done_o is a single-cycle pulse. word_o carries the result while done_o is high and holds it until the next read completes.
- R8: A start_i pulse, or a change of addr_i, wide_i or half_div_i, while a read is in progress does not alter the running read and does not launch another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle read request, taken only when idle |
| addr_i | input | 8 | Word address (upper two bits unused in narrow mode) |
| wide_i | input | 1 | 1 selects an 8-bit address field, 0 a 6-bit one |
| half_div_i | input | 8 | System clocks per serial phase (0 acts as 1) |
| do_i | input | 1 | Serial data from the EEPROM |
| cs_o | output | 1 | Chip select to the EEPROM, active high |
| sk_o | output | 1 | Serial shift clock |
| di_o | output | 1 | Serial data to the EEPROM |
| done_o | output | 1 | One-cycle pulse, result valid |
| word_o | output | 16 | Last word read |

## Verification
Two events can land in the same cycle: a fresh start request, and the sequencer advancing a phase mid-read. The bench provokes this by pulsing start_i a few cycles into a read while it also flips addr_i and wide_i. It then checks that the captured command, the sixteen returned bits and the total duration all match the original request. It also checks that chip select stays low after done, which shows that the stray request launched no second read. A reset asserted mid-read is checked to return every serial output to its idle level on the following edge.

// File: rtl/mw_pkg.sv
// Shared types for the serial EEPROM word reader.
// Assumes nothing beyond IEEE 1800-2017 packages.
package mw_pkg;

    // Sequencer phases; each non-idle phase except FINISH lasts one timer period.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SELECT = 3'd1,
        ST_CMD_LO = 3'd2,
        ST_CMD_HI = 3'd3,
        ST_GAP    = 3'd4,
        ST_DAT_HI = 3'd5,
        ST_DAT_LO = 3'd6,
        ST_FINISH = 3'd7
    } mw_state_t;

endpackage

// File: rtl/mw_phase_timer.sv
// Phase timer: pulses tick_o on the last system clock of each phase.
// A phase lasts len_i clocks. Assumes len_i >= 1 and that len_i is stable while run_i is high.
// The count restarts whenever run_i is low.
module mw_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] len_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == len_i - 1'b1);

    // Count clocks within the current phase; wrap on tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < len_i));  // R5

endmodule

// File: rtl/mw_cmd_builder.sv
// Read-command former: left-aligns {00, 110, address} in a CMD_W-bit field.
// Also reports how many of those bits are sent.
// Purely combinational. Assumes AW_WIDE > AW_NARROW.
module mw_cmd_builder #(
    parameter int AW_NARROW = 6,
    parameter int AW_WIDE   = 8,
    localparam int CMD_W    = AW_WIDE + 5,
    localparam int CNT_W    = $clog2(CMD_W + 1)
) (
    input  logic [AW_WIDE-1:0] addr_i,
    input  logic               wide_i,
    output logic [CMD_W-1:0]   cmd_o,
    output logic [CNT_W-1:0]   nbits_o
);

    localparam int PAD = AW_WIDE - AW_NARROW;

    // Place opcode above the selected address field, MSB aligned.
    always_comb begin
        if (wide_i) begin
            cmd_o   = {2'b00, 3'b110, addr_i};
            nbits_o = CNT_W'(AW_WIDE + 5);
        end else begin
            cmd_o   = {2'b00, 3'b110, addr_i[AW_NARROW-1:0], {PAD{1'b0}}};
            nbits_o = CNT_W'(AW_NARROW + 5);
        end
    end

endmodule

// File: rtl/mw_rx_shift.sv
// Receive shifter: collects serial bits MSB first.
// Publishes the finished word on load_i and holds it until the next load.
// Assumes load_i comes after the final shift_i.
module mw_rx_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              bit_i,
    input  logic              load_i,
    output logic [DATA_W-1:0] word_o
);

    logic [DATA_W-1:0] sr_q;

    // Shift the sampled bit in at the LSB end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (shift_i)
            sr_q <= {sr_q[DATA_W-2:0], bit_i};
    end

    // Hold the published result between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_o <= '0;
        else if (load_i)
            word_o <= sr_q;
    end

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_i) |-> $stable(word_o));  // R7

endmodule

// File: rtl/mw_eeprom_reader.sv
// Serial EEPROM word reader.
// Frames a read with chip select, shifts out a read command, then clocks in DATA_W bits.
// Pulses done_o with the word before it drops chip select.
// Assumes the EEPROM drives do_i after the rising edge of sk_o.
// The bit is captured at the end of the high phase.
module mw_eeprom_reader #(
    parameter int DIV_W     = 8,
    parameter int AW_NARROW = 6,
    parameter int AW_WIDE   = 8,
    parameter int DATA_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [AW_WIDE-1:0] addr_i,
    input  logic               wide_i,
    input  logic [DIV_W-1:0]   half_div_i,
    input  logic               do_i,
    output logic               cs_o,
    output logic               sk_o,
    output logic               di_o,
    output logic               done_o,
    output logic [DATA_W-1:0]  word_o
);

    import mw_pkg::*;

    localparam int CMD_W = AW_WIDE + 5;
    localparam int CNT_W = $clog2(CMD_W + 1);
    localparam int IDX_W = $clog2((CMD_W > DATA_W ? CMD_W : DATA_W) + 1);

    mw_state_t        state_q;
    logic [CMD_W-1:0] cmd_sr_q;
    logic [IDX_W-1:0] idx_q;
    logic [DIV_W-1:0] len_q;
    logic [CMD_W-1:0] cmd_w;
    logic [CNT_W-1:0] nbits_w;
    logic             tick;
    logic             run;
    logic             accept;

    mw_cmd_builder #(
        .AW_NARROW (AW_NARROW),
        .AW_WIDE   (AW_WIDE)
    ) i_cmd (
        .addr_i  (addr_i),
        .wide_i  (wide_i),
        .cmd_o   (cmd_w),
        .nbits_o (nbits_w)
    );

    assign run    = (state_q != ST_IDLE) && (state_q != ST_FINISH);
    assign accept = (state_q == ST_IDLE) && start_i;

    mw_phase_timer #(
        .DIV_W (DIV_W)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .len_i  (len_q),
        .tick_o (tick)
    );

    mw_rx_shift #(
        .DATA_W (DATA_W)
    ) i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (tick && (state_q == ST_DAT_HI)),
        .bit_i   (do_i),
        .load_i  (tick && (state_q == ST_DAT_LO) && (idx_q == '0)),
        .word_o  (word_o)
    );

    // Sequencer: advances one phase per timer tick, captures request on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cmd_sr_q <= '0;
            idx_q    <= '0;
            len_q    <= DIV_W'(1);
        end else if (accept) begin
            state_q  <= ST_SELECT;
            cmd_sr_q <= cmd_w;
            idx_q    <= IDX_W'(nbits_w - 1'b1);
            len_q    <= (half_div_i == '0) ? DIV_W'(1) : half_div_i;
        end else if (state_q == ST_FINISH) begin
            state_q <= ST_IDLE;
        end else if (tick) begin
            case (state_q)
                ST_SELECT: state_q <= ST_CMD_LO;
                ST_CMD_LO: state_q <= ST_CMD_HI;
                ST_CMD_HI: begin
                    cmd_sr_q <= {cmd_sr_q[CMD_W-2:0], 1'b0};
                    if (idx_q == '0) begin
                        state_q <= ST_GAP;
                    end else begin
                        idx_q   <= idx_q - 1'b1;
                        state_q <= ST_CMD_LO;
                    end
                end
                ST_GAP: begin
                    idx_q   <= IDX_W'(DATA_W - 1);
                    state_q <= ST_DAT_HI;
                end
                ST_DAT_HI: state_q <= ST_DAT_LO;
                ST_DAT_LO: begin
                    if (idx_q == '0) begin
                        state_q <= ST_FINISH;
                    end else begin
                        idx_q   <= idx_q - 1'b1;
                        state_q <= ST_DAT_HI;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Pin levels decoded from the registered phase.
    always_comb begin
        cs_o   = (state_q != ST_IDLE) && (state_q != ST_SELECT);
        sk_o   = (state_q == ST_CMD_HI) || (state_q == ST_DAT_HI);
        di_o   = ((state_q == ST_CMD_LO) || (state_q == ST_CMD_HI)) && cmd_sr_q[CMD_W-1];
        done_o = (state_q == ST_FINISH);
    end

    AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sk_o |-> cs_o);  // R6
    AST_DI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sk_o && $past(sk_o)) |-> $stable(di_o));  // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R7
    AST_DONE_DROPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !cs_o);  // R6
    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SELECT) && ($past(state_q) != ST_SELECT)) |-> ($past(state_q) == ST_IDLE));  // R8
    AST_SELECT_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_o) |-> ($past(state_q) == ST_SELECT));  // R6

endmodule

// File: tb/test_mw_eeprom_reader.sv
// Bench for the serial EEPROM word reader: a vector table walked by one loop, then directed reset cases.
module test_mw_eeprom_reader;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] addr_i = '0;
    logic       wide_i = 1'b0;
    logic [7:0] half_div_i = '0;
    logic       do_i = 1'b0;
    logic       cs_o, sk_o, di_o, done_o;
    logic [15:0] word_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mw_eeprom_reader i_mw_eeprom_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .addr_i     (addr_i),
        .wide_i     (wide_i),
        .half_div_i (half_div_i),
        .do_i       (do_i),
        .cs_o       (cs_o),
        .sk_o       (sk_o),
        .di_o       (di_o),
        .done_o     (done_o),
        .word_o     (word_o)
    );

    // EEPROM model: resets on chip-select rise and counts clock rises.
    // It captures command bits and serves data bits.
    int          edges = 0;
    int          nexp = 11;
    logic [12:0] cmd_cap = '0;
    logic [15:0] mem_word = '0;
    int          di_in_data = 0;
    int          sk_no_cs = 0;
    always @(posedge sk_o or posedge cs_o) begin
        if (!sk_o) begin
            edges      = 0;
            cmd_cap    = '0;
            di_in_data = 0;
        end else begin
            if (!cs_o) sk_no_cs++;
            if (edges < nexp) begin
                cmd_cap = {cmd_cap[11:0], di_o};
            end else begin
                if (di_o) di_in_data++;
                if (edges - nexp < 16) do_i <= mem_word[15 - (edges - nexp)];
            end
            edges++;
        end
    end

    // Count changes of di_o while sk_o stays high.
    int   di_glitch = 0;
    logic prev_sk = 1'b0, prev_di = 1'b0;
    always @(negedge clk) begin
        if (sk_o && prev_sk && (di_o != prev_di)) di_glitch++;
        prev_sk = sk_o;
        prev_di = di_o;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Vector: {interfere, wide, addr[7:0], div[7:0], data[15:0]}
    localparam int NV = 6;
    localparam logic [33:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'h00, 8'd1, 16'hA55A},
        {1'b0, 1'b1, 8'hFF, 8'd0, 16'h1234},
        {1'b0, 1'b0, 8'h3F, 8'd3, 16'hFFFF},
        {1'b0, 1'b1, 8'hA5, 8'd2, 16'h0000},
        {1'b1, 1'b0, 8'hC7, 8'd1, 16'h8001},
        {1'b1, 1'b1, 8'h5A, 8'd4, 16'h7E81}
    };

    task automatic run_read(input bit intf, input bit wide, input logic [7:0] addr,
                            input logic [7:0] div, input logic [15:0] data);
        int n;
        int len;
        int nb;
        logic [12:0] exp_cmd;
        len = (div == 0) ? 1 : int'(div);
        nb  = wide ? 13 : 11;
        exp_cmd = wide ? {5'b00110, addr} : {7'b0000110, addr[5:0]};
        nexp = nb;
        mem_word = data;
        @(negedge clk);
        start_i = 1'b1; addr_i = addr; wide_i = wide; half_div_i = div;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check(!cs_o && !sk_o, "R6 cs low in select phase", {30'b0, cs_o, sk_o}, 0);
        n = 0;
        while (!done_o && n < 2000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (intf && n == 5) begin
                start_i = 1'b1; addr_i = ~addr; wide_i = ~wide; half_div_i = div + 8'd3;
            end else begin
                start_i = 1'b0;
            end
        end
        start_i = 1'b0;
        check(n == (2*nb + 34) * len, intf ? "R8 R5 duration" : "R5 duration", n, (2*nb + 34) * len);
        check(cmd_cap == exp_cmd, intf ? "R8 R2 command bits" : "R2 command bits", cmd_cap, exp_cmd);
        check(edges == nb + 16, "R4 clock pulse count", edges, nb + 16);
        check(di_in_data == 0, "R4 di low in data phase", di_in_data, 0);
        check(word_o == data, intf ? "R8 R4 word" : "R4 word", word_o, data);
        check(sk_no_cs == 0, "R6 sk only with cs", sk_no_cs, 0);
        check(di_glitch == 0, "R3 di stable while sk high", di_glitch, 0);
        @(negedge clk);
        check(!done_o, "R7 done single cycle", done_o, 0);
        check(!cs_o, "R6 cs low after done", cs_o, 0);
        check(word_o == data, "R7 word held", word_o, data);
        repeat (3) @(negedge clk);
        check(!cs_o && !done_o, "R8 no second read launched", {30'b0, cs_o, done_o}, 0);
        check(word_o == data, "R7 word held idle", word_o, data);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({cs_o, sk_o, di_o, done_o} == 4'b0, "R1 reset outputs", {cs_o, sk_o, di_o, done_o}, 0);
        check(word_o == 16'h0, "R1 reset word", word_o, 0);
        rst_n = 1'b1;
        for (int v = 0; v < NV; v++) begin
            run_read(VEC[v][33], VEC[v][32], VEC[v][31:24], VEC[v][23:16], VEC[v][15:0]);
        end
        // Directed: reset in the middle of a read.
        nexp = 11;
        mem_word = 16'hBEEF;
        @(negedge clk);
        start_i = 1'b1; addr_i = 8'h12; wide_i = 1'b0; half_div_i = 8'd2;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        check(cs_o, "R6 cs high mid read", cs_o, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check({cs_o, sk_o, di_o, done_o} == 4'b0, "R1 reset mid read", {cs_o, sk_o, di_o, done_o}, 0);
        check(word_o == 16'h0, "R1 reset clears word", word_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // A fresh read after the reset still works.
        run_read(1'b0, 1'b1, 8'h81, 8'd1, 16'hC3C3);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

endmodule